// File: doc/BRIEF.md
# EPP-capable parallel port host controller

This block sits between a simple byte-oriented register bus and the pins of a PC-style parallel port. Software writes an output data latch and a control register and reads back a status byte sampled from the peripheral. That covers plain printer-style output. Two further offsets start Enhanced Parallel Port transfers. For these the controller runs the strobe/wait handshake with the peripheral on its own. It signals completion to the bus only when the handshake has ended or has timed out.

An EPP transfer is started only when the control register holds the exact idle pattern for that direction. Any other pattern drops the access without a strobe: a dropped write has no effect and a dropped read returns all ones. The data port also accepts 16-bit and 32-bit accesses. These are split into byte cycles, least significant byte first. If the peripheral fails to answer within the timeout window, the controller abandons the access and sets a sticky timeout flag. Software clears that flag explicitly.

Top module: `epp_host_ctrl`

## Requirements
- R1: After reset, offset 2 reads 0xCC, offset 0 reads 0xFF (direction 0), status bit 0 is 0, and every requested register access completes with `bus_ready` one cycle after the request.
- R2: A control write stores bits 5:0 (bit 0 strobe, bit 1 auto-feed, bit 2 init, bit 3 select-in, bit 4 interrupt enable, bit 5 direction); a control read always returns 1 in bits 7 and 6.
- R3: Outside an EPP cycle the pins follow the control register: `pp_strobe_n` = ~bit0, `pp_autofd_n` = ~bit1, `pp_init_n` = bit2, `pp_selin_n` = ~bit3, `pp_dir_in` = bit5.
- R4: A read of offset 0 returns `pp_din` when control bit 5 is 1, and otherwise the last byte written to offset 0; `pp_dout` shows that byte.
- R5: A read of offset 1 returns {`pp_stat`[4:0], 2'b00, timeout flag}; `pp_stat`[4] is also the peripheral wait line.
- R6: A write to offset 3 (address) or 4 (data) runs EPP cycles only when control bits under mask 0x2F equal 0x04; otherwise it is dropped and no strobe occurs.
- R7: A read of offset 3 or 4 runs EPP cycles only when the masked control bits equal 0x24; otherwise it returns 0xFFFFFFFF and no strobe occurs.
- R8: Each EPP byte cycle drives `pp_autofd_n` low for a write (high for a read). It pulls `pp_strobe_n` low for offset 4 or `pp_selin_n` low for offset 3. It holds the strobe until the wait line rises, sampling `pp_din` then for a read. It releases the strobe and finishes only after the wait line falls.
- R9: On offset 4, `bus_be` 4'b0011 moves 2 bytes and 4'b1111 moves 4 bytes, least significant byte first; any other value moves one byte, and offset 3 always moves one. Read lanes not filled by a completed byte return 0xFF.
- R10: If a byte cycle does not finish within TMO_CYCLES clocks, the strobes are released, the timeout flag is set, and the remaining bytes are skipped.
- R11: The timeout flag stays set until a write to offset 1 with bit 0 set; a status write with bit 0 clear leaves it set.
- R12: Requests arriving while an EPP access is in progress are ignored, and each accepted access produces exactly one single-cycle `bus_ready` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write request (one cycle) |
| bus_rd | input | 1 | Read request (one cycle) |
| bus_be | input | 4 | Byte enables, select EPP data width |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access complete pulse |
| pp_dout | output | 8 | Data lines driven to peripheral |
| pp_din | input | 8 | Data lines sampled from peripheral |
| pp_dir_in | output | 1 | 1 = data lines released for input |
| pp_strobe_n | output | 1 | Strobe / EPP data strobe |
| pp_autofd_n | output | 1 | Auto-feed / EPP write line |
| pp_init_n | output | 1 | Initialize line |
| pp_selin_n | output | 1 | Select-in / EPP address strobe |
| pp_stat | input | 5 | Status lines for bits 7:3, bit 4 is wait |

## Verification
The bench builds the controller with CLK_HZ = 2 MHz, so the 10 microsecond window becomes 20 clocks. This puts the timeout abort of a wide write in reach of a short run, next to normal handshakes whose peripheral answers after 3 clocks. Byte-ordering, gating patterns and the ignore-while-busy rule then sit within a few hundred cycles.

// File: rtl/epp_pkg.sv
package epp_pkg;
    localparam logic [2:0] OFF_DATA = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd1;
    localparam logic [2:0] OFF_CTRL = 3'd2;
    localparam logic [2:0] OFF_EADR = 3'd3;
    localparam logic [2:0] OFF_EDAT = 3'd4;

    localparam int CB_STB = 0;
    localparam int CB_AFD = 1;
    localparam int CB_INI = 2;
    localparam int CB_SEL = 3;
    localparam int CB_DIR = 5;

    localparam logic [5:0] CTL_GATE_MASK = 6'h2F;
    localparam logic [5:0] CTL_GATE_WR   = 6'h04;
    localparam logic [5:0] CTL_GATE_RD   = 6'h24;
    localparam logic [5:0] CTL_RESET     = 6'h0C;

    typedef enum logic {HS_IDLE_ST = 1'b0, HS_EPP_ST = 1'b1} host_st_e;
    typedef enum logic [1:0] {EN_IDLE = 2'd0, EN_STRB = 2'd1, EN_REL = 2'd2} eng_st_e;

    function automatic logic [2:0] be_to_bytes(input logic [3:0] be);
        case (be)
            4'b1111: return 3'd4;
            4'b0011: return 3'd2;
            default: return 3'd1;
        endcase
    endfunction
endpackage

// File: rtl/epp_timer.sv
module epp_timer #(
    parameter int LIMIT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)
            cnt_d = '0;
        else if (run_i && cnt_q != LAST)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == LAST);

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= LAST);
endmodule

// File: rtl/epp_cycle_eng.sv
module epp_cycle_eng #(
    parameter int TMO_CYCLES = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       is_read_i,
    input  logic       is_addr_i,
    input  logic       wait_i,
    input  logic [7:0] din_i,
    output logic       done_o,
    output logic       fail_o,
    output logic [7:0] rd_byte_o,
    output logic       write_n_o,
    output logic       dstrb_n_o,
    output logic       astrb_n_o
);
    import epp_pkg::*;

    typedef struct packed {
        eng_st_e    st;
        logic       done;
        logic       fail;
        logic [7:0] rbyte;
        logic       write_n;
        logic       dstrb_n;
        logic       astrb_n;
    } eng_t;

    eng_t d, q;
    logic expired;

    epp_timer #(.LIMIT(TMO_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start_i),
        .run_i    (q.st != EN_IDLE),
        .expired_o(expired)
    );

    always_comb begin
        d = q;
        d.done = 1'b0;
        d.fail = 1'b0;
        unique case (q.st)
            EN_IDLE: begin
                if (start_i) begin
                    d.st      = EN_STRB;
                    d.write_n = is_read_i;
                    d.dstrb_n = is_addr_i;
                    d.astrb_n = !is_addr_i;
                end
            end
            EN_STRB: begin
                if (expired) begin
                    d.st = EN_IDLE; d.done = 1'b1; d.fail = 1'b1;
                    d.write_n = 1'b1; d.dstrb_n = 1'b1; d.astrb_n = 1'b1;
                end else if (wait_i) begin
                    d.st = EN_REL; d.rbyte = din_i;
                    d.dstrb_n = 1'b1; d.astrb_n = 1'b1;
                end
            end
            EN_REL: begin
                if (expired) begin
                    d.st = EN_IDLE; d.done = 1'b1; d.fail = 1'b1;
                    d.write_n = 1'b1;
                end else if (!wait_i) begin
                    d.st = EN_IDLE; d.done = 1'b1;
                    d.write_n = 1'b1;
                end
            end
            default: d.st = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st <= EN_IDLE; q.done <= 1'b0; q.fail <= 1'b0; q.rbyte <= 8'hFF;
            q.write_n <= 1'b1; q.dstrb_n <= 1'b1; q.astrb_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done_o    = q.done;
    assign fail_o    = q.fail;
    assign rd_byte_o = q.rbyte;
    assign write_n_o = q.write_n;
    assign dstrb_n_o = q.dstrb_n;
    assign astrb_n_o = q.astrb_n;

    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!q.dstrb_n && !q.astrb_n));
    // R10
    fail_releases_chk: assert property (@(posedge clk) disable iff (!rst_n) q.fail |-> (q.dstrb_n && q.astrb_n));
    // R8
    strobe_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.dstrb_n) || $fell(q.astrb_n)) |-> $past(start_i));
endmodule

// File: rtl/epp_host_ctrl.sv
module epp_host_ctrl #(
    parameter int CLK_HZ = 50_000_000,
    parameter int TMO_NS = 10_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ready,
    output logic [7:0]  pp_dout,
    input  logic [7:0]  pp_din,
    output logic        pp_dir_in,
    output logic        pp_strobe_n,
    output logic        pp_autofd_n,
    output logic        pp_init_n,
    output logic        pp_selin_n,
    input  logic [4:0]  pp_stat
);
    import epp_pkg::*;

    localparam int TMO_RAW    = ((CLK_HZ / 1000) * TMO_NS) / 1_000_000;
    localparam int TMO_CYCLES = (TMO_RAW < 2) ? 2 : TMO_RAW;

    typedef struct packed {
        host_st_e    st;
        logic [7:0]  dataw;
        logic [5:0]  ctl;
        logic        tmo;
        logic        ready;
        logic [31:0] rdata;
        logic        start;
        logic        isrd;
        logic        isadr;
        logic [2:0]  nb;
        logic [1:0]  idx;
        logic [31:0] wbuf;
        logic [31:0] rbuf;
    } host_t;

    host_t d, q;
    logic       eng_done, eng_fail, eng_wr_n, eng_ds_n, eng_as_n;
    logic [7:0] eng_rbyte;
    logic       gate_wr, gate_rd;
    logic [31:0] rbuf_nxt;

    epp_cycle_eng #(.TMO_CYCLES(TMO_CYCLES)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (q.start),
        .is_read_i(q.isrd),
        .is_addr_i(q.isadr),
        .wait_i   (pp_stat[4]),
        .din_i    (pp_din),
        .done_o   (eng_done),
        .fail_o   (eng_fail),
        .rd_byte_o(eng_rbyte),
        .write_n_o(eng_wr_n),
        .dstrb_n_o(eng_ds_n),
        .astrb_n_o(eng_as_n)
    );

    assign gate_wr = (q.ctl & CTL_GATE_MASK) == CTL_GATE_WR;
    assign gate_rd = (q.ctl & CTL_GATE_MASK) == CTL_GATE_RD;

    always_comb begin
        d = q;
        d.ready = 1'b0;
        d.start = 1'b0;
        rbuf_nxt = q.rbuf;
        unique case (q.st)
            HS_IDLE_ST: begin
                if (bus_wr || bus_rd) begin
                    d.ready = 1'b1;
                    d.rdata = '0;
                    case (bus_addr)
                        OFF_DATA: begin
                            if (bus_wr) d.dataw = bus_wdata[7:0];
                            else        d.rdata[7:0] = q.ctl[CB_DIR] ? pp_din : q.dataw;
                        end
                        OFF_STAT: begin
                            if (bus_wr) begin
                                if (bus_wdata[0]) d.tmo = 1'b0;
                            end else begin
                                d.rdata[7:0] = {pp_stat, 2'b00, q.tmo};
                            end
                        end
                        OFF_CTRL: begin
                            if (bus_wr) d.ctl = bus_wdata[5:0];
                            else        d.rdata[7:0] = {2'b11, q.ctl};
                        end
                        OFF_EADR, OFF_EDAT: begin
                            if ((bus_wr && gate_wr) || (!bus_wr && gate_rd)) begin
                                d.ready = 1'b0;
                                d.st    = HS_EPP_ST;
                                d.start = 1'b1;
                                d.isrd  = !bus_wr;
                                d.isadr = (bus_addr == OFF_EADR);
                                d.nb    = (bus_addr == OFF_EADR) ? 3'd1 : be_to_bytes(bus_be);
                                d.idx   = 2'd0;
                                d.wbuf  = bus_wdata;
                                d.rbuf  = '1;
                            end else if (!bus_wr) begin
                                d.rdata = '1;
                            end
                        end
                        default: begin
                            if (!bus_wr) d.rdata[7:0] = 8'hFF;
                        end
                    endcase
                end
            end
            HS_EPP_ST: begin
                if (eng_done) begin
                    if (q.isrd && !eng_fail) rbuf_nxt[q.idx*8 +: 8] = eng_rbyte;
                    d.rbuf = rbuf_nxt;
                    if (eng_fail || ({1'b0, q.idx} == q.nb - 3'd1)) begin
                        if (eng_fail) d.tmo = 1'b1;
                        d.st    = HS_IDLE_ST;
                        d.ready = 1'b1;
                        d.rdata = q.isrd ? rbuf_nxt : '0;
                    end else begin
                        d.idx   = q.idx + 2'd1;
                        d.start = 1'b1;
                    end
                end
            end
            default: d.st = HS_IDLE_ST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st <= HS_IDLE_ST; q.dataw <= 8'hFF; q.ctl <= CTL_RESET; q.tmo <= 1'b0;
            q.ready <= 1'b0; q.rdata <= '0; q.start <= 1'b0; q.isrd <= 1'b0;
            q.isadr <= 1'b0; q.nb <= 3'd1; q.idx <= 2'd0; q.wbuf <= '0; q.rbuf <= '1;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata   = q.rdata;
    assign bus_ready   = q.ready;
    assign pp_dout     = (q.st == HS_EPP_ST && !q.isrd) ? q.wbuf[q.idx*8 +: 8] : q.dataw;
    assign pp_dir_in   = q.ctl[CB_DIR];
    assign pp_strobe_n = ~q.ctl[CB_STB] & eng_ds_n;
    assign pp_autofd_n = ~q.ctl[CB_AFD] & eng_wr_n;
    assign pp_init_n   = q.ctl[CB_INI];
    assign pp_selin_n  = ~q.ctl[CB_SEL] & eng_as_n;

    // R12
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) q.ready |=> !q.ready);
    // R10
    tmo_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(q.tmo) |-> $past(eng_fail));
    // R11
    tmo_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.tmo) |-> $past(bus_wr && bus_addr == OFF_STAT && bus_wdata[0] && q.st == HS_IDLE_ST));
    // R6
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.start && !q.isrd) |-> ((q.ctl & CTL_GATE_MASK) == CTL_GATE_WR));
    // R7
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.start && q.isrd) |-> ((q.ctl & CTL_GATE_MASK) == CTL_GATE_RD));
endmodule

// File: tb/tb_epp_host_ctrl.sv
module tb_epp_host_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DLY = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_be = 4'b0001;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_ready;
    logic [7:0] pp_dout, pp_din;
    logic pp_dir_in, pp_strobe_n, pp_autofd_n, pp_init_n, pp_selin_n;
    logic [4:0] pp_stat;
    logic pwait = 1'b0;
    logic [3:0] stat_lo = 4'b1010;
    logic [7:0] din_r = 8'h00;
    logic [7:0] rd_val = 8'h80;
    logic pm_en = 1'b0, dead = 1'b0, cur_rd = 1'b0;
    int n_chk = 0, n_fail = 0, scnt = 0, rcnt = 0;

    typedef struct { logic [31:0] v; string tag; } exp_t;
    exp_t rdq[$];
    logic [8:0] pwq[$];

    assign pp_stat = {pwait, stat_lo};
    assign pp_din  = din_r;

    always #(CLK_PERIOD/2) clk = ~clk;

    epp_host_ctrl #(.CLK_HZ(2_000_000), .TMO_NS(10_000)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .pp_dout(pp_dout), .pp_din(pp_din), .pp_dir_in(pp_dir_in), .pp_strobe_n(pp_strobe_n),
        .pp_autofd_n(pp_autofd_n), .pp_init_n(pp_init_n), .pp_selin_n(pp_selin_n), .pp_stat(pp_stat)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // monitor: read results and ready pulses
    initial forever begin
        @(negedge clk);
        if (bus_ready) begin
            rcnt++;
            if (cur_rd) begin
                if (rdq.size() == 0) chk(1'b0, "R12 unexpected read", bus_rdata, 32'h0);
                else begin
                    exp_t e;
                    e = rdq.pop_front();
                    chk(bus_rdata === e.v, e.tag, bus_rdata, e.v);
                end
            end
        end
    end

    // peripheral model and write-byte scoreboard
    initial forever begin
        @(negedge clk);
        if (pm_en && (!pp_strobe_n || !pp_selin_n)) begin
            logic is_a, is_w;
            scnt++;
            is_a = !pp_selin_n;
            is_w = !pp_autofd_n;
            if (is_w) begin
                if (pwq.size() == 0) chk(1'b0, "R6 unexpected strobe", {23'h0, is_a, pp_dout}, 32'h0);
                else begin
                    logic [8:0] e;
                    e = pwq.pop_front();
                    chk({is_a, pp_dout} === e, "R8 R9 write byte", {23'h0, is_a, pp_dout}, {23'h0, e});
                end
            end
            if (!dead) begin
                repeat (DLY) @(negedge clk);
                din_r = rd_val;
                pwait = 1'b1;
                while (!pp_strobe_n || !pp_selin_n) @(negedge clk);
                if (!is_w) rd_val = rd_val + 8'd1;
                repeat (DLY) @(negedge clk);
                pwait = 1'b0;
            end else begin
                while (!pp_strobe_n || !pp_selin_n) @(negedge clk);
            end
        end
    end

    task automatic acc(input logic wr, input logic [2:0] a, input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        cur_rd = !wr;
        bus_addr = a; bus_be = be; bus_wdata = wd; bus_wr = wr; bus_rd = !wr;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        while (!bus_ready) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] wd);
        acc(1'b1, a, be, wd);
    endtask

    task automatic rd(input logic [2:0] a, input logic [3:0] be, input logic [31:0] exp, input string tag);
        exp_t e;
        e.v = exp; e.tag = tag;
        rdq.push_back(e);
        acc(1'b0, a, be, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int s0, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(bus_ready === 1'b0, "R1 ready idle", {31'h0, bus_ready}, 32'h0);
        rd(3'd2, 4'b0001, 32'h0000_00CC, "R1 control reset");
        rd(3'd0, 4'b0001, 32'h0000_00FF, "R1 data reset");
        rd(3'd1, 4'b0001, {24'h0, 1'b0, stat_lo, 3'b000}, "R1 R5 status reset");
        // R4 output latch
        wr(3'd0, 4'b0001, 32'h5A);
        rd(3'd0, 4'b0001, 32'h5A, "R4 data readback dir0");
        @(negedge clk);
        chk(pp_dout === 8'h5A, "R4 pp_dout", {24'h0, pp_dout}, 32'h5A);
        // R2 control readback
        wr(3'd2, 4'b0001, 32'h00);
        rd(3'd2, 4'b0001, 32'hC0, "R2 control bits 7:6");
        wr(3'd2, 4'b0001, 32'h3F);
        rd(3'd2, 4'b0001, 32'hFF, "R2 control all");
        // R3 pin mapping
        wr(3'd2, 4'b0001, 32'h0B);
        @(negedge clk);
        chk({pp_strobe_n, pp_autofd_n, pp_init_n, pp_selin_n, pp_dir_in} === 5'b00000,
            "R3 pins for 0x0B", {27'h0, pp_strobe_n, pp_autofd_n, pp_init_n, pp_selin_n, pp_dir_in}, 32'h0);
        wr(3'd2, 4'b0001, 32'h24);
        @(negedge clk);
        chk({pp_strobe_n, pp_autofd_n, pp_init_n, pp_selin_n, pp_dir_in} === 5'b11111,
            "R3 pins for 0x24", {27'h0, pp_strobe_n, pp_autofd_n, pp_init_n, pp_selin_n, pp_dir_in}, 32'h1F);
        // R4 data input with dir=1
        din_r = 8'hC3;
        rd(3'd0, 4'b0001, 32'hC3, "R4 data read dir1");
        // R5 status pins
        stat_lo = 4'b0101;
        rd(3'd1, 4'b0001, {24'h0, 1'b0, 4'b0101, 3'b000}, "R5 status pins");
        pm_en = 1'b1;
        // R8 address write
        wr(3'd2, 4'b0001, 32'h04);
        pwq.push_back({1'b1, 8'h3C});
        wr(3'd3, 4'b1111, 32'hAABB_CC3C);
        // R9 wide data write, LSB first
        pwq.push_back({1'b0, 8'h44}); pwq.push_back({1'b0, 8'h33});
        pwq.push_back({1'b0, 8'h22}); pwq.push_back({1'b0, 8'h11});
        wr(3'd4, 4'b1111, 32'h1122_3344);
        chk(scnt == 5, "R9 strobe count after writes", scnt, 5);
        // R6 gated write dropped (autofd bit set)
        wr(3'd2, 4'b0001, 32'h06);
        s0 = scnt;
        wr(3'd4, 4'b0001, 32'h99);
        repeat (4) @(negedge clk);
        chk(scnt == s0, "R6 dropped write no strobe", scnt, s0);
        // R7 gated read returns ones
        wr(3'd2, 4'b0001, 32'h04);
        rd(3'd4, 4'b0011, 32'hFFFF_FFFF, "R7 dropped read");
        repeat (4) @(negedge clk);
        chk(scnt == s0, "R7 dropped read no strobe", scnt, s0);
        // R7 R9 valid 16-bit read then address read
        wr(3'd2, 4'b0001, 32'h24);
        rd(3'd4, 4'b0011, 32'hFFFF_8180, "R9 16-bit read order");
        rd(3'd3, 4'b0001, 32'hFFFF_FF82, "R8 address read");
        chk(scnt == s0 + 3, "R8 read strobes", scnt, s0 + 3);
        // R12 request ignored while busy
        wr(3'd2, 4'b0001, 32'h04);
        pwq.push_back({1'b0, 8'h01}); pwq.push_back({1'b0, 8'h02});
        r0 = rcnt;
        fork
            wr(3'd4, 4'b0011, 32'h0201);
            begin
                repeat (4) @(negedge clk);
                bus_addr = 3'd2; bus_wdata = 32'h3F; bus_wr = 1'b1;
                @(negedge clk);
                bus_wr = 1'b0;
            end
        join
        repeat (3) @(negedge clk);
        chk(rcnt == r0 + 1, "R12 single ready", rcnt, r0 + 1);
        rd(3'd2, 4'b0001, 32'hC4, "R12 busy write ignored");
        // R10 timeout aborts wide write
        dead = 1'b1;
        s0 = scnt;
        pwq.push_back({1'b0, 8'hD4});
        wr(3'd4, 4'b1111, 32'hA1B2_C3D4);
        repeat (6) @(negedge clk);
        chk(scnt == s0 + 1, "R10 remaining bytes skipped", scnt, s0 + 1);
        chk(pp_strobe_n === 1'b1, "R10 strobe released", {31'h0, pp_strobe_n}, 32'h1);
        rd(3'd1, 4'b0001, {24'h0, 1'b0, 4'b0101, 3'b001}, "R10 timeout flag set");
        dead = 1'b0;
        // R11 clear rules
        wr(3'd1, 4'b0001, 32'hFE);
        rd(3'd1, 4'b0001, {24'h0, 1'b0, 4'b0101, 3'b001}, "R11 write bit0=0 keeps flag");
        wr(3'd1, 4'b0001, 32'h01);
        rd(3'd1, 4'b0001, {24'h0, 1'b0, 4'b0101, 3'b000}, "R11 write bit0=1 clears");
        repeat (4) @(negedge clk);
        chk(rdq.size() == 0, "R12 all reads answered", rdq.size(), 0);
        chk(pwq.size() == 0, "R8 all write bytes seen", pwq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule